// File: doc/BRIEF.md
# Paired-Byte Access Bridge for 16-bit Registers

This block lets an 8-bit data bus move 16-bit values in and out of a group of wide peripheral registers (a running counter, two compare values and a capture value) as single, indivisible transfers. One 8-bit holding byte is shared by every wide register.

On a write, software first writes the upper byte, which only parks the data in the holding byte. It then writes the lower byte. That second write produces a one-cycle commit strobe for the selected register, together with the full 16-bit word: the holding byte on top and the bus byte below. On a read, software first reads the lower byte. It receives the live lower byte, and the live upper byte of the same cycle is frozen into the holding byte. A following upper-byte read then returns that frozen copy, so both halves come from one instant even if the register keeps changing.

The bridge does not count, compare or capture. It only sees the live values and issues the commit strobes. Because the holding byte is shared, two accesses that interleave on different registers see each other's upper byte.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the holding byte is zero. An upper-byte read right after reset returns 0x00, and a lower-byte-only write right after reset commits a word whose upper byte is 0x00.
- R2: A write with `addr[0]`=1 (upper byte) loads `wrData` into the holding byte at the clock edge and raises no commit strobe.
- R3: A write with `addr[0]`=0 (lower byte) raises, in the same cycle, exactly one bit of `commitStb`: bit `addr[2:1]`. `commitData` carries {holding byte, `wrData`}. At most one strobe bit is ever high.
- R4: A read with `addr[0]`=0 returns, in the same cycle, bits 7:0 of the selected live word on `rdData`.
- R5: A read with `addr[0]`=0 (and no upper-byte write) copies bits 15:8 of the selected live word, as seen in that cycle, into the holding byte at the clock edge.
- R6: A read with `addr[0]`=1 returns the holding byte, not the live upper byte. With `rdEn` low, `rdData` is 0x00.
- R7: The holding byte is shared. An upper-byte write aimed at one register, followed by a lower-byte write to another, commits the parked byte to the second register.
- R8: A lower-byte read followed by an upper-byte read yields a coherent 16-bit pair, even if the live word changes between the two accesses.
- R9: With `rdEn` and `wrEn` high in the same cycle at one address, both take effect. On an upper byte, `rdData` shows the old holding byte and the holding byte takes `wrData`. On a lower byte, the commit uses the old holding byte and the holding byte then takes the live upper byte.
- R10: Address encoding: `addr[2:1]` selects the register (0 counter, 1 compare A, 2 compare B, 3 capture). Live word `k` sits at `liveVals[16k+15:16k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Byte address: register select and upper/lower byte |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| liveVals | input | 64 | Live 16-bit values of the four registers, packed |
| rdData | output | 8 | Read byte, valid in the cycle of `rdEn` |
| commitStb | output | 4 | One-cycle commit strobe per register |
| commitData | output | 16 | Word to commit when a strobe is high |

## Verification
The read path and the write path can land in the same cycle, and both then compete for the holding byte. The bench raises `rdEn` and `wrEn` together at an upper-byte address and again at a lower-byte address, in directed cases and in a share of the random cycles. It judges the result by `rdData` and `commitData` in that cycle, and by what a later upper-byte read returns. A reference model built from R9 supplies the expected values.

// File: rtl/wide_reg_bridge_pkg.sv
package wide_reg_bridge_pkg;
  typedef struct packed {
    logic tempFromBus;   // park the write byte
    logic tempFromLive;  // snapshot live upper byte
    logic commit;        // lower-byte write
    logic readHigh;      // return holding byte
    logic readLow;       // return live lower byte
  } ctrlStb_t;
endpackage

// File: rtl/wide_reg_bridge_ctrl.sv
module wide_reg_bridge_ctrl
  import wide_reg_bridge_pkg::*;
#(
  parameter int REG_COUNT = 4,
  localparam int SEL_W = $clog2(REG_COUNT),
  localparam int ADDR_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output ctrlStb_t          stb,
  output logic [SEL_W-1:0]  regSel,
  output logic [REG_COUNT-1:0] commitStb
);
  logic hiByte;

  always_comb begin
    hiByte           = addr[0];
    regSel           = addr[ADDR_W-1:1];
    stb.tempFromBus  = wrEn & hiByte;
    stb.tempFromLive = rdEn & ~hiByte;
    stb.commit       = wrEn & ~hiByte;
    stb.readHigh     = rdEn & hiByte;
    stb.readLow      = rdEn & ~hiByte;
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_stb
    assign commitStb[i] = stb.commit && (regSel == SEL_W'(i));
  end

  // R3: never more than one commit target
  p_commit_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(commitStb));
  // R2: an upper-byte write commits nothing
  p_high_write_no_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[0]) |-> (commitStb == '0));
  // R3: a lower-byte write always commits somewhere
  p_low_write_commits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr[0]) |-> ($countones(commitStb) == 1));
endmodule

// File: rtl/wide_reg_bridge_dp.sv
module wide_reg_bridge_dp
  import wide_reg_bridge_pkg::*;
#(
  parameter int REG_COUNT = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int SEL_W = $clog2(REG_COUNT)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStb_t                    stb,
  input  logic [SEL_W-1:0]            regSel,
  input  logic [BYTE_W-1:0]           wrData,
  input  logic [REG_COUNT*WORD_W-1:0] liveVals,
  output logic [BYTE_W-1:0]           rdData,
  output logic [WORD_W-1:0]           commitData
);
  logic [WORD_W-1:0] liveWord [REG_COUNT];
  logic [WORD_W-1:0] selWord;
  logic [BYTE_W-1:0] tempByte;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_live
    assign liveWord[i] = liveVals[i*WORD_W +: WORD_W];
  end

  assign selWord = liveWord[regSel];

  always_ff @(posedge clk) begin
    if (!rstN)                 tempByte <= '0;
    else if (stb.tempFromBus)  tempByte <= wrData;
    else if (stb.tempFromLive) tempByte <= selWord[WORD_W-1:BYTE_W];
  end

  always_comb begin
    rdData = '0;
    if (stb.readLow)       rdData = selWord[BYTE_W-1:0];
    else if (stb.readHigh) rdData = tempByte;
  end

  assign commitData = {tempByte, wrData};

  // R2: parked byte equals the written byte
  p_temp_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.tempFromBus |=> (tempByte == $past(wrData)));
  // R5: lower-byte read freezes the live upper byte
  p_snapshot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tempFromLive && !stb.tempFromBus) |=> (tempByte == $past(selWord[WORD_W-1:BYTE_W])));
  // R7: upper-byte write then lower-byte write commits the parked byte
  p_commit_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tempFromBus ##1 stb.commit) |-> (commitData[WORD_W-1:BYTE_W] == $past(wrData)));
  // R6: holding byte untouched when no access touches it
  p_temp_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tempFromBus && !stb.tempFromLive) |=> $stable(tempByte));
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wide_reg_bridge_pkg::*;
#(
  parameter int REG_COUNT = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int SEL_W = $clog2(REG_COUNT),
  localparam int ADDR_W = SEL_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        rdEn,
  input  logic                        wrEn,
  input  logic [BYTE_W-1:0]           wrData,
  input  logic [REG_COUNT*WORD_W-1:0] liveVals,
  output logic [BYTE_W-1:0]           rdData,
  output logic [REG_COUNT-1:0]        commitStb,
  output logic [WORD_W-1:0]           commitData
);
  ctrlStb_t         stb;
  logic [SEL_W-1:0] regSel;

  wide_reg_bridge_ctrl #(.REG_COUNT(REG_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .stb(stb), .regSel(regSel), .commitStb(commitStb)
  );

  wide_reg_bridge_dp #(.REG_COUNT(REG_COUNT), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel), .wrData(wrData),
    .liveVals(liveVals), .rdData(rdData), .commitData(commitData)
  );
endmodule

// File: tb/wide_reg_bridge_tb_top.sv
module wide_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [15:0] live [4];
  logic [63:0] liveVals;
  logic [7:0]  rdData;
  logic [3:0]  commitStb;
  logic [15:0] commitData;

  int checks = 0;
  int errors = 0;
  logic [7:0] mTemp = '0;   // reference holding byte

  always #2 clk = ~clk;     // 250 MHz

  always_comb liveVals = {live[3], live[2], live[1], live[0]};

  wide_reg_bridge dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .liveVals(liveVals), .rdData(rdData),
    .commitStb(commitStb), .commitData(commitData)
  );

  function automatic logic [7:0] expRd(bit rd, logic [2:0] a, logic [7:0] t);
    if (!rd) return 8'h00;
    return a[0] ? t : live[a[2:1]][7:0];
  endfunction

  function automatic logic [3:0] expStb(bit wr, logic [2:0] a);
    return (wr && !a[0]) ? (4'b0001 << a[2:1]) : 4'b0000;
  endfunction

  function automatic logic [7:0] nextTemp(bit rd, bit wr, logic [2:0] a, logic [7:0] d, logic [7:0] t);
    if (wr && a[0]) return d;
    if (rd && !a[0]) return live[a[2:1]][15:8];
    return t;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one access, check outputs mid-cycle, advance model at the edge
  task automatic access(bit rd, bit wr, logic [2:0] a, logic [7:0] d, string tag);
    logic [3:0] es;
    rdEn = rd; wrEn = wr; addr = a; wrData = d;
    #1;
    es = expStb(wr, a);
    check({tag, " rdData"}, 32'(rdData), 32'(expRd(rd, a, mTemp)));
    check({tag, " commitStb"}, 32'(commitStb), 32'(es));
    if (es != 0) check({tag, " commitData"}, 32'(commitData), 32'({mTemp, d}));
    @(posedge clk);
    mTemp = nextTemp(rd, wr, a, d, mTemp);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) live[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: holding byte zero after reset
    access(1, 0, 3'd1, 8'h00, "R1 hi read after reset");
    access(0, 1, 3'd0, 8'h5A, "R1 lo-only write");
    check("R1 lo-only commit word", 32'(mTemp), 32'h0);

    // R2 / R3: upper then lower write to compare A
    access(0, 1, 3'd3, 8'hAB, "R2 hi write no commit");
    access(0, 1, 3'd2, 8'hCD, "R3 lo write commit cmpA");

    // R7: interleaved targets share the holding byte
    access(0, 1, 3'd3, 8'h12, "R7 hi write cmpA");
    access(0, 1, 3'd4, 8'h34, "R7 lo write cmpB");

    // R4 / R5 / R6 / R8: coherent read while live word moves
    live[0] = 16'h12FF;
    access(1, 0, 3'd0, 8'h00, "R4 lo read counter");
    live[0] = 16'h1300;
    access(1, 0, 3'd1, 8'h00, "R8 hi read snapshot");
    check("R6 hi read not live", 32'(mTemp), 32'h12);

    // R9: simultaneous read and write
    live[3] = 16'h9876;
    access(1, 1, 3'd7, 8'h44, "R9 rd+wr hi capture");
    access(1, 1, 3'd6, 8'h55, "R9 rd+wr lo capture");
    access(1, 0, 3'd7, 8'h00, "R9 hi read after collision");

    // R6: idle read bus
    access(0, 0, 3'd5, 8'hFF, "R6 idle rdData zero");

    // R10: random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] op;
      for (int k = 0; k < 4; k++) live[k] = 16'($urandom);
      op = 2'($urandom);
      access(op[0], op[1], 3'($urandom), 8'($urandom), "R10 random");
    end

    finishRun();
  end
endmodule